// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

A combinational integer arithmetic and logic unit assembled from a row of identical one-bit cells. Every cell holds a bitwise AND gate, a bitwise OR gate, a full adder with a selectable inverter on its B input, and a comparison input. A three-bit operation code drives all cells in parallel. Its low two bits choose which of the four cell outputs reaches the result bit. Its top bit inverts B in every cell and also feeds the carry into cell 0, so the same adder chain performs both addition and two's-complement subtraction.

The most significant cell also has a small unit that forms the signed-overflow indication and the signed-compare bit. That compare bit is routed back to the comparison input of cell 0, and every other comparison input is tied low, so set-on-less-than yields 0 or 1 in bit 0 only. A zero detector watches the final result, which lets a subtraction followed by a test of the zero flag serve as an equality check. The unit has no clock and no state: its outputs settle from its inputs.

Top module: `alu_bitslice`

## Requirements
- R1: Operation code 3'b000 returns the bitwise AND of the two operands, with the overflow flag low.
- R2: Operation code 3'b001 returns the bitwise OR of the two operands, with the overflow flag low.
- R3: Operation code 3'b010 returns (A + B) mod 2^32, and the carry output equals bit 32 of the unsigned sum.
- R4: Operation code 3'b110 returns (A - B) mod 2^32, computed as A + ~B + 1, and the carry output is 1 exactly when A >= B as unsigned numbers.
- R5: During addition the overflow flag is 1 exactly when the operands share a sign bit (bit 31) and the result's sign bit differs from it.
- R6: During subtraction the overflow flag is 1 exactly when the operands' sign bits differ and the result's sign bit differs from A's sign bit.
- R7: Operation code 3'b111 returns 1 in bit 0 when A < B as signed two's-complement numbers, including cases where A - B overflows, and returns 0 in bits 31..1, with the overflow flag low.
- R8: The zero flag is 1 exactly when all 32 result bits are 0, so subtracting equal operands raises it.
- R9: The unused operation codes 3'b011, 3'b100 and 3'b101 drive a result of 0, a low overflow flag and a high zero flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a_i | input | 32 | First operand A |
| opnd_b_i | input | 32 | Second operand B |
| op_i | input | 3 | Operation code; bit 2 inverts B and supplies the initial carry |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when every result bit is 0 |
| overflow_o | output | 1 | Signed overflow of addition or subtraction |
| carry_o | output | 1 | Carry leaving the most significant cell |

## Verification
The unit holds no state, so a wrong internal value shows up at the ports as soon as the inputs settle, in the same sample. A broken carry link shows only when a carry has to travel through that cell. For this reason the bench uses operands such as all-ones plus one, where the carry runs the full length of the chain. The signed-compare feedback is only exposed by operand pairs whose difference overflows: most-negative against positive, and most-positive against negative. Those pairs are checked directly, because a compare bit taken from the raw sign of the difference would pass every other comparison.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam logic [2:0] OPC_AND = 3'b000;
   localparam logic [2:0] OPC_OR  = 3'b001;
   localparam logic [2:0] OPC_ADD = 3'b010;
   localparam logic [2:0] OPC_SUB = 3'b110;
   localparam logic [2:0] OPC_SLT = 3'b111;

   typedef enum logic [1:0] {
      SEL_AND  = 2'b00,
      SEL_OR   = 2'b01,
      SEL_SUM  = 2'b10,
      SEL_LESS = 2'b11
   } alu_sel_e;

   function automatic logic op_is_legal(input logic [2:0] op);
      return (op == OPC_AND) || (op == OPC_OR) || (op == OPC_ADD) ||
             (op == OPC_SUB) || (op == OPC_SLT);
   endfunction

   function automatic logic op_is_arith(input logic [2:0] op);
      return (op == OPC_ADD) || (op == OPC_SUB);
   endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
   import alu_pkg::*;
(
   input  logic     a_i,
   input  logic     b_i,
   input  logic     carry_i,
   input  logic     less_i,
   input  logic     b_negate_i,
   input  alu_sel_e sel_i,
   output logic     result_o,
   output logic     carry_o
);

   logic b_eff;
   logic sum;

   always_comb begin
      b_eff   = b_i ^ b_negate_i;
      sum     = a_i ^ b_eff ^ carry_i;
      carry_o = (a_i & b_eff) | (a_i & carry_i) | (b_eff & carry_i);
      unique case (sel_i)
         SEL_AND:  result_o = a_i & b_eff;
         SEL_OR:   result_o = a_i | b_eff;
         SEL_SUM:  result_o = sum;
         SEL_LESS: result_o = less_i;
         default:  result_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu_msb_unit.sv
module alu_msb_unit (
   input  logic a_msb_i,
   input  logic b_msb_i,
   input  logic b_negate_i,
   input  logic carry_in_i,
   input  logic carry_out_i,
   output logic set_o,
   output logic ovf_o
);

   logic b_eff;

   always_comb begin
      b_eff = b_msb_i ^ b_negate_i;
      ovf_o = carry_in_i ^ carry_out_i;
      // the sign of the difference, corrected by overflow, equals a ^ b_eff ^ carry_out
      set_o = a_msb_i ^ b_eff ^ carry_out_i;
   end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
   parameter int WIDTH = 32,
   parameter int CHUNK = 8
) (
   input  logic [WIDTH-1:0] value_i,
   output logic             zero_o
);

   localparam int NCHUNK = (WIDTH + CHUNK - 1) / CHUNK;
   localparam int PADW   = NCHUNK * CHUNK;

   logic [PADW-1:0]   padded;
   logic [NCHUNK-1:0] part_any;

   generate
      if (CHUNK < 1) begin : g_bad_chunk
         $error("alu_zero_detect: CHUNK must be at least 1");
      end
      if (PADW > WIDTH) begin : g_pad
         assign padded = {{(PADW-WIDTH){1'b0}}, value_i};
      end else begin : g_nopad
         assign padded = value_i;
      end
      for (genvar k = 0; k < NCHUNK; k++) begin : g_part
         assign part_any[k] = |padded[k*CHUNK +: CHUNK];
      end
   endgenerate

   assign zero_o = ~|part_any;

endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
   import alu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int ZERO_CHUNK = 8
) (
   input  logic [WIDTH-1:0] opnd_a_i,
   input  logic [WIDTH-1:0] opnd_b_i,
   input  logic [2:0]       op_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o,
   output logic             overflow_o,
   output logic             carry_o
);

   localparam int MSB = WIDTH - 1;

   logic             b_negate;
   alu_sel_e         sel;
   logic             legal;
   logic             arith;
   logic [WIDTH:0]   carry;
   logic [WIDTH-1:0] less;
   logic [WIDTH-1:0] raw_result;
   logic             set_bit;
   logic             ovf_raw;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_bitslice: WIDTH must be at least 2");
      end
   endgenerate

   always_comb begin
      b_negate = op_i[2];
      sel      = alu_sel_e'(op_i[1:0]);
      legal    = op_is_legal(op_i);
      arith    = op_is_arith(op_i);
   end

   assign carry[0] = b_negate;
   assign less     = {{(WIDTH-1){1'b0}}, set_bit};

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_slice
         alu_slice u_slice (
            .a_i        (opnd_a_i[i]),
            .b_i        (opnd_b_i[i]),
            .carry_i    (carry[i]),
            .less_i     (less[i]),
            .b_negate_i (b_negate),
            .sel_i      (sel),
            .result_o   (raw_result[i]),
            .carry_o    (carry[i+1])
         );
      end
   endgenerate

   alu_msb_unit u_msb (
      .a_msb_i     (opnd_a_i[MSB]),
      .b_msb_i     (opnd_b_i[MSB]),
      .b_negate_i  (b_negate),
      .carry_in_i  (carry[MSB]),
      .carry_out_i (carry[WIDTH]),
      .set_o       (set_bit),
      .ovf_o       (ovf_raw)
   );

   assign result_o   = legal ? raw_result : '0;
   assign overflow_o = arith & ovf_raw;
   assign carry_o    = carry[WIDTH];

   alu_zero_detect #(
      .WIDTH (WIDTH),
      .CHUNK (ZERO_CHUNK)
   ) u_zero (
      .value_i (result_o),
      .zero_o  (zero_o)
   );

   always_comb begin
      if (op_i == OPC_ADD) begin
         a_r5_add_overflow: assert (overflow_o ==
            ((opnd_a_i[MSB] == opnd_b_i[MSB]) && (result_o[MSB] != opnd_a_i[MSB])));
      end
      if (op_i == OPC_SUB) begin
         a_r6_sub_overflow: assert (overflow_o ==
            ((opnd_a_i[MSB] != opnd_b_i[MSB]) && (result_o[MSB] != opnd_a_i[MSB])));
      end
      if (op_i == OPC_SLT) begin
         a_r7_slt_upper_clear: assert (result_o[MSB:1] == '0 && !overflow_o);
      end
      a_r8_zero_flag: assert (zero_o == (result_o == '0));
      if (!op_is_legal(op_i)) begin
         a_r9_unused_quiet: assert (result_o == '0 && !overflow_o && zero_o);
      end
      if (op_i == OPC_AND || op_i == OPC_OR) begin
         a_r1_r2_logic_no_overflow: assert (!overflow_o);
      end
   end

endmodule

// File: tb/alu_bitslice_bench.sv
module alu_bitslice_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic [31:0] a_in = '0;
   logic [31:0] b_in = '0;
   logic [2:0]  op_in = 3'b000;
   logic [31:0] result;
   logic        zero;
   logic        overflow;
   logic        carry;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_bitslice u_alu_bitslice (
      .opnd_a_i   (a_in),
      .opnd_b_i   (b_in),
      .op_i       (op_in),
      .result_o   (result),
      .zero_o     (zero),
      .overflow_o (overflow),
      .carry_o    (carry)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h (a=%h b=%h op=%b)",
                  tag, what, act, exp, a_in, b_in, op_in);
      end
   endtask

   task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
      @(negedge clk);
      a_in  = a;
      b_in  = b;
      op_in = op;
      @(posedge clk);
      #1;
   endtask

   // full reference comparison for any operation code
   task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] op);
      logic [32:0] wide;
      logic [31:0] exp_r;
      logic        exp_ov;
      logic        exp_c;
      logic        chk_c;
      exp_ov = 1'b0;
      exp_c  = 1'b0;
      chk_c  = 1'b0;
      case (op)
         3'b000: exp_r = a & b;
         3'b001: exp_r = a | b;
         3'b010: begin
            wide   = {1'b0, a} + {1'b0, b};
            exp_r  = wide[31:0];
            exp_c  = wide[32];
            chk_c  = 1'b1;
            exp_ov = (a[31] == b[31]) && (exp_r[31] != a[31]);
         end
         3'b110: begin
            exp_r  = a - b;
            exp_c  = (a >= b);
            chk_c  = 1'b1;
            exp_ov = (a[31] != b[31]) && (exp_r[31] != a[31]);
         end
         3'b111: exp_r = {31'b0, ($signed(a) < $signed(b))};
         default: exp_r = '0;
      endcase
      drive(a, b, op);
      check(tag, "result", result, exp_r);
      check(tag, "overflow", {31'b0, overflow}, {31'b0, exp_ov});
      check("R8", "zero", {31'b0, zero}, {31'b0, (exp_r == 32'd0)});
      if (chk_c) check(tag, "carry", {31'b0, carry}, {31'b0, exp_c});
   endtask

   task automatic t_logic_ops();
      run_op("R1", 32'hF0F0_A5A5, 32'h0FF0_FFFF, 3'b000);
      run_op("R1", 32'hFFFF_FFFF, 32'h8000_0001, 3'b000);
      run_op("R1", 32'h1234_5678, 32'h0000_0000, 3'b000);
      run_op("R2", 32'hF0F0_0000, 32'h0000_0F0F, 3'b001);
      run_op("R2", 32'h0000_0000, 32'h0000_0000, 3'b001);
      run_op("R2", 32'h8000_0000, 32'h7FFF_FFFF, 3'b001);
   endtask

   task automatic t_add();
      run_op("R3", 32'd5, 32'd7, 3'b010);
      run_op("R3", 32'hFFFF_FFFF, 32'd1, 3'b010);       // carry runs the full chain
      run_op("R3", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b010);
      run_op("R5", 32'h7FFF_FFFF, 32'd1, 3'b010);       // positive overflow
      run_op("R5", 32'h8000_0000, 32'h8000_0000, 3'b010); // negative overflow
      run_op("R5", 32'h7FFF_FFFF, 32'h8000_0000, 3'b010); // mixed signs, never overflow
   endtask

   task automatic t_sub();
      run_op("R4", 32'd9, 32'd4, 3'b110);
      run_op("R4", 32'd4, 32'd9, 3'b110);
      run_op("R4", 32'd0, 32'd0, 3'b110);
      run_op("R6", 32'h8000_0000, 32'd1, 3'b110);
      run_op("R6", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
      run_op("R6", 32'hFFFF_FFFF, 32'hFFFF_FFFE, 3'b110); // same signs, no overflow
   endtask

   task automatic t_slt();
      run_op("R7", 32'd3, 32'd8, 3'b111);
      run_op("R7", 32'd8, 32'd3, 3'b111);
      run_op("R7", 32'hFFFF_FFFF, 32'd0, 3'b111);       // -1 < 0
      run_op("R7", 32'd0, 32'hFFFF_FFFF, 3'b111);
      run_op("R7", 32'h8000_0000, 32'd1, 3'b111);       // difference overflows, still less
      run_op("R7", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111); // difference overflows, not less
      run_op("R7", 32'h1234_0000, 32'h1234_0000, 3'b111); // equal
   endtask

   task automatic t_equality();
      run_op("R8", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110);
      run_op("R8", 32'hDEAD_BEEF, 32'hDEAD_BEEE, 3'b110);
      run_op("R8", 32'h0000_FFFF, 32'hFFFF_0000, 3'b000);
   endtask

   task automatic t_unused();
      run_op("R9", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);
      run_op("R9", 32'h7FFF_FFFF, 32'h8000_0000, 3'b100);
      run_op("R9", 32'h1234_5678, 32'h0000_0001, 3'b101);
   endtask

   task automatic t_random();
      logic [2:0] ops [5];
      ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110; ops[4] = 3'b111;
      for (int i = 0; i < 300; i++) begin
         logic [31:0] ra;
         logic [31:0] rb;
         logic [2:0]  rop;
         ra  = $urandom;
         rb  = (i % 7 == 0) ? ra : $urandom;
         rop = ops[i % 5];
         case (rop)
            3'b000:  run_op("R1", ra, rb, rop);
            3'b001:  run_op("R2", ra, rb, rop);
            3'b010:  run_op("R3", ra, rb, rop);
            3'b110:  run_op("R4", ra, rb, rop);
            default: run_op("R7", ra, rb, rop);
         endcase
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      for (int cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0A1B));
      t_logic_ops();
      t_add();
      t_sub();
      t_slt();
      t_equality();
      t_unused();
      t_random();
      finish_run();
   end

endmodule